// File: doc/BRIEF.md
# Summing and Scaling Accumulator

This block keeps a 32-bit signed running total that either the processor or a converter sample stream can feed. The processor sees it as six byte registers on a small register port: four data bytes, one control byte and one status byte. In the processor modes, the upper three data bytes are staged. A write to the lowest data byte then launches an add or a subtract of the assembled 32-bit word into the total.

In sample mode, the block takes signed samples from a valid/ready stream. It sums a power-of-two number of them, then divides the total by a power of two with an arithmetic right shift, which gives an average. A shift-only variant loads a word written by the processor, already shifted, in one step. Any result outside the signed 32-bit range raises a sticky error flag. Each completed batch or shift raises a done flag, which stays set until the processor reads a data byte.

Sample stream rules: a sample transfers on a rising clock edge where both `smp_valid` and `smp_ready` are high. `smp_ready` does not depend on `smp_valid`. It is high only in sample mode (not shift-only) while the done flag is clear. A finished batch therefore holds the stream back until software reads the result. A source must keep `smp_data` steady while `smp_valid` is high and `smp_ready` is low.

Top module: `sum_shift_accum`

## Requirements
- R1: Register map. Address 0 to 3 read the total's bytes, with address 0 the least significant. Address 4 is control: mode in bits 1:0, count code N in bits 4:2 and shift S in bits 7:5. Reading address 4 returns the value last written. Address 5 reads overflow in bit 0 and done in bit 1. Mode codes: 00 clear, 01 add, 10 subtract, 11 sample.
- R2: After reset the total, the control byte and both flags are zero, and `smp_ready` is low.
- R3: In add mode, writing address 0 adds the word {byte3, byte2, byte1, written byte} to the total on that clock edge. Writes to addresses 1 to 3 alone leave the total unchanged.
- R4: In subtract mode, writing address 0 subtracts the assembled word from the total.
- R5: While the mode is clear, the total and the sample counter are forced to zero on every clock edge. The edge after the control write therefore leaves both at zero.
- R6: In sample mode with N from 0 to 6, each accepted sample is sign-extended from 24 bits and added to the total. The sample that completes a batch of 2^(N+1) samples instead stores (total + sample) arithmetically shifted right by S, sets done, and restarts the count.
- R7: In sample mode with N = 7 (shift-only), `smp_ready` is low. Writing address 0 loads the assembled word shifted arithmetically right by S and sets done.
- R8: The overflow flag sets when an add or subtract result lies outside the signed 32-bit range. The stored total wraps. The flag clears only on a write of 0 to status bit 0. Writing 1 there has no effect, and a set in the same cycle wins over the clear.
- R9: Done clears on a read of any of addresses 0 to 3. While done is set, `smp_ready` is low.
- R10: In sample mode with N below 7, a write to address 0 leaves the total unchanged. In the processor modes, `smp_ready` is low and offered samples leave the total unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (used for done clearing) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from address |
| smp_valid | input | 1 | Sample offered |
| smp_ready | output | 1 | Sample can be taken |
| smp_data | input | 24 | Signed converter sample |
| done_flag | output | 1 | Batch or shift completed, interrupt request |
| ovf_flag | output | 1 | Sticky out-of-range flag |

## Verification
Two things can land on one edge: a software write clearing the overflow flag, and an arriving sample whose sum leaves the signed range. The bench provokes this by loading the total with the largest positive value through shift-only mode. It then offers a sample of +1 on the same edge as a status write of zero. It judges the outcome by reading the flag as set and the total as the wrapped value 0x80000000. The other pairing, done being set and cleared together, is excluded by back-pressure, and the bench checks this through `smp_ready` staying low after a finished batch.

// File: rtl/sas_pkg.sv
package sas_pkg;
  typedef enum logic [1:0] {
    MD_CLEAR  = 2'b00,
    MD_ADD    = 2'b01,
    MD_SUB    = 2'b10,
    MD_SAMPLE = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    OP_ADD,
    OP_SUB,
    OP_ADD_SHIFT,
    OP_LOAD_SHIFT
  } op_e;
endpackage

// File: rtl/sas_ctrl.sv
module sas_ctrl
  import sas_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SMP_W  = 24,
  parameter int CODE_W = 3,
  parameter int SH_W   = 3,
  parameter int AW     = 3,
  localparam int CTRL_W = 2 + CODE_W + SH_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [AW-1:0]     reg_addr,
  input  logic [CTRL_W-1:0] reg_wdata,
  input  logic              smp_valid,
  input  logic [SMP_W-1:0]  smp_data,
  input  logic              done_q,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              clr,
  output logic              op_go,
  output op_e               op_sel,
  output logic [DATA_W-1:0] operand,
  output logic [SH_W-1:0]   shamt,
  output logic              finish,
  output logic              smp_ready
);
  localparam int NB    = DATA_W / 8;
  localparam int CNT_W = (1 << CODE_W) - 1;

  mode_e             mode;
  logic [CODE_W-1:0] code;
  logic              shift_only, lo_wr, smp_go, last;
  logic [7:0]        stage_q [1:NB-1];
  logic [DATA_W-1:0] cpu_word, smp_ext;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W:0]    tgt_m1;

  assign mode       = mode_e'(ctrl_q[1:0]);
  assign code       = ctrl_q[2 +: CODE_W];
  assign shamt      = ctrl_q[2+CODE_W +: SH_W];
  assign shift_only = (mode == MD_SAMPLE) && (code == {CODE_W{1'b1}});
  assign clr        = (mode == MD_CLEAR);
  assign lo_wr      = reg_wr && (reg_addr == '0);
  assign smp_ready  = (mode == MD_SAMPLE) && !shift_only && !done_q;
  assign smp_go     = smp_valid && smp_ready;
  assign smp_ext    = {{(DATA_W-SMP_W){smp_data[SMP_W-1]}}, smp_data};
  assign tgt_m1     = ((CNT_W+1)'(1) << (code + CODE_W'(1))) - (CNT_W+1)'(1);
  assign last       = ({1'b0, cnt_q} == tgt_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      for (int k = 1; k < NB; k++) stage_q[k] <= '0;
    end else if (reg_wr) begin
      if (reg_addr == AW'(NB)) ctrl_q <= reg_wdata;
      for (int k = 1; k < NB; k++)
        if (reg_addr == AW'(k)) stage_q[k] <= reg_wdata[7:0];
    end
  end

  always_comb begin
    cpu_word[7:0] = reg_wdata[7:0];
    for (int k = 1; k < NB; k++) cpu_word[8*k +: 8] = stage_q[k];
  end

  always_comb begin
    op_go   = 1'b0;
    op_sel  = OP_ADD;
    operand = cpu_word;
    finish  = 1'b0;
    case (mode)
      MD_ADD: op_go = lo_wr;
      MD_SUB: begin
        op_go  = lo_wr;
        op_sel = OP_SUB;
      end
      MD_SAMPLE: begin
        if (shift_only) begin
          op_go  = lo_wr;
          op_sel = OP_LOAD_SHIFT;
          finish = lo_wr;
        end else begin
          op_go   = smp_go;
          operand = smp_ext;
          op_sel  = last ? OP_ADD_SHIFT : OP_ADD;
          finish  = smp_go && last;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr)    cnt_q <= '0;
    else if (smp_go) cnt_q <= last ? '0 : cnt_q + CNT_W'(1);
  end

  // R5: clear mode empties the sample counter by the next edge
  a_r5_count_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));

  // R10: no sample is taken outside sample mode
  a_r10_no_take_outside_sample: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MD_SAMPLE) |-> !smp_ready);
endmodule

// File: rtl/sas_alu.sv
module sas_alu
  import sas_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SH_W   = 3
) (
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] operand,
  input  op_e               op_sel,
  input  logic [SH_W-1:0]   shamt,
  output logic [DATA_W-1:0] res,
  output logic              ovf
);
  logic [DATA_W:0] a_x, b_x, sum;
  logic            sum_out;

  assign a_x     = {acc[DATA_W-1], acc};
  assign b_x     = {operand[DATA_W-1], operand};
  assign sum     = (op_sel == OP_SUB) ? (a_x - b_x) : (a_x + b_x);
  assign sum_out = sum[DATA_W] ^ sum[DATA_W-1];

  always_comb begin
    case (op_sel)
      OP_ADD_SHIFT: begin
        res = DATA_W'($signed(sum[DATA_W-1:0]) >>> shamt);
        ovf = sum_out;
      end
      OP_LOAD_SHIFT: begin
        res = DATA_W'($signed(operand) >>> shamt);
        ovf = 1'b0;
      end
      default: begin
        res = sum[DATA_W-1:0];
        ovf = sum_out;
      end
    endcase
  end
endmodule

// File: rtl/sum_shift_accum.sv
module sum_shift_accum
  import sas_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SMP_W  = 24,
  parameter int CODE_W = 3,
  parameter int SH_W   = 3,
  parameter int AW     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [AW-1:0]    reg_addr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             smp_valid,
  output logic             smp_ready,
  input  logic [SMP_W-1:0] smp_data,
  output logic             done_flag,
  output logic             ovf_flag
);
  localparam int NB        = DATA_W / 8;
  localparam int CTRL_W    = 2 + CODE_W + SH_W;
  localparam int ADDR_CTRL = NB;
  localparam int ADDR_STAT = NB + 1;

  logic [DATA_W-1:0] acc_q, operand, alu_res;
  logic [CTRL_W-1:0] ctrl_q;
  logic [SH_W-1:0]   shamt;
  logic              clr, op_go, finish, alu_ovf;
  logic              ovf_q, done_q, stat_clr, data_rd;
  op_e               op_sel;

  sas_ctrl #(.DATA_W(DATA_W), .SMP_W(SMP_W), .CODE_W(CODE_W), .SH_W(SH_W), .AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata[CTRL_W-1:0]), .smp_valid(smp_valid), .smp_data(smp_data),
    .done_q(done_q), .ctrl_q(ctrl_q), .clr(clr), .op_go(op_go), .op_sel(op_sel),
    .operand(operand), .shamt(shamt), .finish(finish), .smp_ready(smp_ready)
  );

  sas_alu #(.DATA_W(DATA_W), .SH_W(SH_W)) u_alu (
    .acc(acc_q), .operand(operand), .op_sel(op_sel), .shamt(shamt),
    .res(alu_res), .ovf(alu_ovf)
  );

  assign stat_clr = reg_wr && (reg_addr == AW'(ADDR_STAT)) && !reg_wdata[0];
  assign data_rd  = reg_rd && (reg_addr < AW'(NB));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      ovf_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (clr)        acc_q <= '0;
      else if (op_go) acc_q <= alu_res;
      if (op_go && alu_ovf) ovf_q <= 1'b1;
      else if (stat_clr)    ovf_q <= 1'b0;
      if (finish)       done_q <= 1'b1;
      else if (data_rd) done_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int k = 0; k < NB; k++)
      if (reg_addr == AW'(k)) reg_rdata = acc_q[8*k +: 8];
    if (reg_addr == AW'(ADDR_CTRL)) reg_rdata = 8'(ctrl_q);
    if (reg_addr == AW'(ADDR_STAT)) reg_rdata = {6'd0, done_q, ovf_q};
  end

  assign done_flag = done_q;
  assign ovf_flag  = ovf_q;

  // R5: clear mode leaves a zero total
  a_r5_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_q == '0));

  // R8: the overflow flag only drops on a software zero write
  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !stat_clr) |=> ovf_q);

  // R9: a finished result holds the sample stream back
  a_r9_ready_low_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !smp_ready);

  // R6: completion raises done on the next edge
  a_r6_finish_sets_done: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> done_q);

  // R10: without an operation or clear the total does not move
  a_r10_total_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_go && !clr) |=> $stable(acc_q));
endmodule

// File: tb/sum_shift_accum_bench.sv
module sum_shift_accum_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic [23:0] smp_data = '0;
  logic        done_flag, ovf_flag;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  sum_shift_accum u_sum_shift_accum (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .smp_valid(smp_valid),
    .smp_ready(smp_ready), .smp_data(smp_data), .done_flag(done_flag), .ovf_flag(ovf_flag)
  );

  // {subtract, operand, expected total, expected overflow}
  localparam logic [65:0] VEC [0:5] = '{
    {1'b0, 32'h0000_0005, 32'h0000_0005, 1'b0},
    {1'b0, 32'hFFFF_FFFE, 32'h0000_0003, 1'b0},
    {1'b1, 32'h0000_0010, 32'hFFFF_FFF3, 1'b0},
    {1'b0, 32'h7FFF_FFF0, 32'h7FFF_FFE3, 1'b0},
    {1'b0, 32'h0000_0100, 32'h8000_00E3, 1'b1},
    {1'b1, 32'h0000_0001, 32'h8000_00E2, 1'b1}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_acc(output logic [31:0] v);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = 3'(i);
      #1 v[8*i +: 8] = reg_rdata;
    end
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wr_word(input logic [31:0] w);
    wr(3'd3, w[31:24]); wr(3'd2, w[23:16]); wr(3'd1, w[15:8]); wr(3'd0, w[7:0]);
  endtask

  task automatic sample(input logic [23:0] d);
    @(negedge clk);
    smp_valid = 1'b1; smp_data = d;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state
    check(done_flag == 1'b0, "R2 done", 32'(done_flag), 32'd0);
    check(ovf_flag == 1'b0, "R2 ovf", 32'(ovf_flag), 32'd0);
    check(smp_ready == 1'b0, "R2 ready", 32'(smp_ready), 32'd0);
    reg_addr = 3'd4; #1;
    check(reg_rdata == 8'h00, "R2 control", 32'(reg_rdata), 32'd0);
    rd_acc(v);
    check(v == 32'd0, "R2 total", v, 32'd0);

    // R3 R4 R8: table of processor operations
    for (int i = 0; i < 6; i++) begin
      wr(3'd4, VEC[i][65] ? 8'h02 : 8'h01);
      wr_word(VEC[i][64:33]);
      rd_acc(v);
      check(v == VEC[i][32:1], VEC[i][65] ? "R4 subtract" : "R3 add", v, VEC[i][32:1]);
      check(ovf_flag == VEC[i][0], "R8 overflow", 32'(ovf_flag), 32'(VEC[i][0]));
    end

    // R8 writing 1 keeps the flag, writing 0 clears it
    wr(3'd5, 8'h01);
    check(ovf_flag == 1'b1, "R8 write one ignored", 32'(ovf_flag), 32'd1);
    wr(3'd5, 8'h00);
    check(ovf_flag == 1'b0, "R8 write zero clears", 32'(ovf_flag), 32'd0);

    // R5 clear mode
    wr(3'd4, 8'h00);
    rd_acc(v);
    check(v == 32'd0, "R5 clear", v, 32'd0);

    // R3 upper byte writes alone, R10 samples in processor mode
    wr(3'd4, 8'h01);
    wr(3'd3, 8'hFF); wr(3'd2, 8'hFF); wr(3'd1, 8'hFF);
    #1 check(smp_ready == 1'b0, "R10 ready low in add mode", 32'(smp_ready), 32'd0);
    sample(24'h000123);
    rd_acc(v);
    check(v == 32'd0, "R3 R10 total untouched", v, 32'd0);

    // R6 R1: four samples, shift by two
    wr(3'd4, 8'h47);
    reg_addr = 3'd4; #1;
    check(reg_rdata == 8'h47, "R1 control readback", 32'(reg_rdata), 32'h47);
    check(smp_ready == 1'b1, "R6 ready in sample mode", 32'(smp_ready), 32'd1);
    sample(24'd10); sample(24'hFFFFFD); sample(24'd7);
    check(done_flag == 1'b0, "R6 not done after three", 32'(done_flag), 32'd0);
    sample(24'd6);
    check(done_flag == 1'b1, "R6 done after four", 32'(done_flag), 32'd1);
    reg_addr = 3'd5; #1;
    check(reg_rdata == 8'h02, "R1 status byte", 32'(reg_rdata), 32'h02);
    check(smp_ready == 1'b0, "R9 ready low while done", 32'(smp_ready), 32'd0);
    sample(24'd100);
    rd_acc(v);
    check(v == 32'd5, "R6 R9 averaged total", v, 32'd5);
    check(done_flag == 1'b0, "R9 read clears done", 32'(done_flag), 32'd0);

    // R10 low byte write in sample mode
    wr(3'd0, 8'h55);
    rd_acc(v);
    check(v == 32'd5, "R10 low byte ignored", v, 32'd5);

    // R6 negative batch rounds toward minus infinity
    wr(3'd4, 8'h00);
    wr(3'd4, 8'h23);
    sample(24'hFFFFFB); sample(24'hFFFFFC);
    check(done_flag == 1'b1, "R6 done after two", 32'(done_flag), 32'd1);
    rd_acc(v);
    check(v == 32'hFFFF_FFFB, "R6 negative average", v, 32'hFFFF_FFFB);

    // R7 shift-only
    wr(3'd4, 8'h7F);
    #1 check(smp_ready == 1'b0, "R7 ready low", 32'(smp_ready), 32'd0);
    wr_word(32'hFFFF_FF80);
    check(done_flag == 1'b1, "R7 done", 32'(done_flag), 32'd1);
    rd_acc(v);
    check(v == 32'hFFFF_FFF0, "R7 shifted load", v, 32'hFFFF_FFF0);

    // R8 same-cycle set and clear: set wins
    wr(3'd4, 8'h1F);
    wr_word(32'h7FFF_FFFF);
    rd_acc(v);
    check(v == 32'h7FFF_FFFF, "R7 load unshifted", v, 32'h7FFF_FFFF);
    wr(3'd4, 8'h03);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd5; reg_wdata = 8'h00;
    smp_valid = 1'b1; smp_data = 24'd1;
    @(negedge clk);
    reg_wr = 1'b0; smp_valid = 1'b0;
    check(ovf_flag == 1'b1, "R8 set beats clear", 32'(ovf_flag), 32'd1);
    rd_acc(v);
    check(v == 32'h8000_0000, "R8 wrapped total", v, 32'h8000_0000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog R1 to R10: run did not end");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule